// File: doc/BRIEF.md
# Backplane Bus Requester with Programmable Release Policy

This block asks for a shared backplane bus on one of four request levels, takes mastership when the arbiter grants it, and hands the bus back according to a programmable policy. A local agent raises `want` while it has transfers to make and pulses `cyc_done` at the end of each transfer cycle. The requester drives a one-hot request vector (bit index equals the level), reports ownership on `bus_busy`, and raises `held` when the bus was taken and pinned by the hold control.

Two policy families exist. With `cfg_policy_en` high, the requester behaves as a streaming-engine requester: it gives up the bus when local work ends, when the data buffer reports full or empty, or when the release mode selected by `cfg_rel_mode` fires on the time-on expiry and/or another requester's demand. With `cfg_policy_en` low, it behaves as a plain requester with a single choice between releasing when done and releasing only when someone else asks. A fair mode holds off the request while the chosen level's line is busy, and a change of level is only adopted at the moment of acquisition, so the very first request after reset is always on the top level.

Top module: `bus_requester`

## Requirements
- R1: After reset `req_out` is all zero, `bus_busy` is low and `held` is low.
- R2: Until the first acquisition after reset, any request is made on level 3 only (`req_out` = 4'b1000), whatever `cfg_level` holds.
- R3: With demand (`want` or `cfg_hold` high) and no fair block, `req_out` shows the active level one edge after demand is seen; when `grant_in` is high while requesting, `bus_busy` rises and `req_out` clears on the next edge.
- R4: The active level is taken from `cfg_level` on the edge where ownership begins; a level change made while owning is used only after the bus has been released and requested once more at the old level.
- R5: With `cfg_fair` high, no request is raised while `bus_req_in[active level]` is high; the request appears one edge after that line drops.
- R6: Ownership ends only at a cycle boundary, meaning an edge where `cyc_done` is high or `want` is low.
- R7: With `cfg_policy_en` high, at a boundary the bus is released when `want` is low, or by `cfg_rel_mode`: 0 = timer expiry AND any `bus_req_in` bit high, 1 = timer expiry, 2 = any `bus_req_in` bit high, 3 = timer expiry OR any `bus_req_in` bit high.
- R8: With `cfg_policy_en` high, `fifo_stop` high at a boundary releases the bus regardless of mode; with `cfg_policy_en` low, `fifo_stop` has no effect.
- R9: With `cfg_policy_en` low, `cfg_rel_done` high releases at a boundary only when `want` is low; `cfg_rel_done` low releases at a boundary only when some `bus_req_in` bit is high.
- R10: With `cfg_hold` high the requester asks for the bus even with `want` low, never releases it, and `held` rises together with `bus_busy`; `held` falls on the edge after `cfg_hold` is cleared.
- R11: After the edge where `bus_busy` falls, `req_out` stays zero for at least that cycle and the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | 2 | Programmed request level |
| cfg_fair | input | 1 | Fair mode enable |
| cfg_hold | input | 1 | Acquire and keep the bus |
| cfg_policy_en | input | 1 | 1: streaming release policy, 0: plain requester |
| cfg_rel_mode | input | 2 | Release mode in streaming policy |
| cfg_rel_done | input | 1 | Plain requester: 1 release when done, 0 release on request |
| want | input | 1 | Local agent has transfers pending |
| cyc_done | input | 1 | End of the current transfer cycle |
| timer_exp | input | 1 | Time-on timer has expired |
| fifo_stop | input | 1 | Data buffer full (reads) or empty (writes) |
| bus_req_in | input | 4 | Other requesters' per-level request lines |
| grant_in | input | 1 | Grant addressed to this requester |
| req_out | output | 4 | One-hot request on the active level |
| bus_busy | output | 1 | This requester owns the bus |
| held | output | 1 | Bus acquired and pinned by the hold control |

## Verification
The hardest situation to reach is the deferred level change: the level must be reprogrammed while the bus is owned, then the bus released and requested again, and only the request after the following grant may use the new value. The stimulus first performs an acquisition from reset to leave the forced top level, changes `cfg_level` mid-ownership, releases through a boundary, and then watches two successive request phases. The release-mode sweep drives every combination of timer expiry and foreign demand against each mode at a boundary, and a separate case holds the release condition true without a boundary to show the bus is kept.

// File: rtl/rq_pkg.sv
// Shared types for the bus requester.
// Assumes: four request levels; the state encoding is private to the block.
package rq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2,
        ST_COOL = 2'd3
    } rq_state_e;

    // Release mode codes for the streaming policy.
    localparam logic [1:0] REL_TMR_AND_REQ = 2'd0;
    localparam logic [1:0] REL_TMR         = 2'd1;
    localparam logic [1:0] REL_REQ         = 2'd2;
    localparam logic [1:0] REL_TMR_OR_REQ  = 2'd3;

endpackage

// File: rtl/rq_level_track.sv
// Holds the level the requester currently asks on.
// Resets to the top level and adopts the programmed level only on the
// acquisition pulse, so changes made at other times are deferred.
module rq_level_track #(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LVL_W-1:0] cfg_level,
    output logic [LVL_W-1:0] active_level
);

    localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(NUM_LEVELS - 1);

    // Latch the programmed level at the start of each ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_level <= TOP_LEVEL;
        end else if (take) begin
            active_level <= cfg_level;
        end
    end

endmodule

// File: rtl/rq_req_drive.sv
// Turns the active level into a one-hot request vector and reports whether
// the line of that level is currently busy (used by fair mode).
// Assumes bus_req_in carries only the other requesters' lines.
module rq_req_drive #(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  enable,
    input  logic [LVL_W-1:0]      level,
    input  logic [NUM_LEVELS-1:0] bus_req_in,
    output logic [NUM_LEVELS-1:0] req_vec,
    output logic                  level_busy
);

    // One decoder bit per level.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        assign req_vec[g] = enable && (level == LVL_W'(g));
    end

    // Line of the selected level, seen by fair mode.
    assign level_busy = bus_req_in[level];

endmodule

// File: rtl/rq_release_policy.sv
// Decides whether an owning requester gives up the bus this cycle.
// Assumes the caller only acts on the result while owning; the decision
// is always suppressed by hold and away from a cycle boundary.
module rq_release_policy
    import rq_pkg::*;
(
    input  logic       policy_en,
    input  logic [1:0] rel_mode,
    input  logic       rel_done,
    input  logic       hold,
    input  logic       boundary,
    input  logic       want,
    input  logic       timer_exp,
    input  logic       fifo_stop,
    input  logic       others_any,
    output logic       release_now
);

    logic mode_hit;

    // Evaluate the selected streaming release mode.
    always_comb begin
        unique case (rel_mode)
            REL_TMR_AND_REQ: mode_hit = timer_exp && others_any;
            REL_TMR:         mode_hit = timer_exp;
            REL_REQ:         mode_hit = others_any;
            default:         mode_hit = timer_exp || others_any;
        endcase
    end

    // Combine family, boundary and hold into the final release decision.
    always_comb begin
        release_now = 1'b0;
        if (!hold && boundary) begin
            if (policy_en) begin
                release_now = !want || fifo_stop || mode_hit;
            end else begin
                release_now = rel_done ? !want : others_any;
            end
        end
    end

endmodule

// File: rtl/bus_requester.sv
// Backplane bus requester: requests on a latched level, owns the bus after
// a grant, releases under a programmable policy at cycle boundaries, and
// idles one cycle after every release.
// Assumes grant_in is addressed to this requester and that no transfer
// cycle is in flight while want is low.
module bus_requester
    import rq_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic                  cfg_fair,
    input  logic                  cfg_hold,
    input  logic                  cfg_policy_en,
    input  logic [1:0]            cfg_rel_mode,
    input  logic                  cfg_rel_done,
    input  logic                  want,
    input  logic                  cyc_done,
    input  logic                  timer_exp,
    input  logic                  fifo_stop,
    input  logic [NUM_LEVELS-1:0] bus_req_in,
    input  logic                  grant_in,
    output logic [NUM_LEVELS-1:0] req_out,
    output logic                  bus_busy,
    output logic                  held
);

    rq_state_e        state_q, state_n;
    logic [LVL_W-1:0] active_level;
    logic             take;
    logic             level_busy;
    logic             release_now;
    logic             demand;
    logic             boundary;
    logic             held_q;

    assign demand   = want || cfg_hold;
    assign boundary = cyc_done || !want;
    assign take     = (state_q == ST_REQ) && grant_in;

    rq_level_track #(.NUM_LEVELS(NUM_LEVELS)) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .cfg_level    (cfg_level),
        .active_level (active_level)
    );

    rq_req_drive #(.NUM_LEVELS(NUM_LEVELS)) u_drive (
        .enable     (state_q == ST_REQ),
        .level      (active_level),
        .bus_req_in (bus_req_in),
        .req_vec    (req_out),
        .level_busy (level_busy)
    );

    rq_release_policy u_policy (
        .policy_en   (cfg_policy_en),
        .rel_mode    (cfg_rel_mode),
        .rel_done    (cfg_rel_done),
        .hold        (cfg_hold),
        .boundary    (boundary),
        .want        (want),
        .timer_exp   (timer_exp),
        .fifo_stop   (fifo_stop),
        .others_any  (|bus_req_in),
        .release_now (release_now)
    );

    // Next-state decision for the request/own/cool-down sequence.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (demand && !(cfg_fair && level_busy)) state_n = ST_REQ;
            ST_REQ: begin
                if (grant_in)     state_n = ST_OWN;
                else if (!demand) state_n = ST_IDLE;
            end
            ST_OWN:  if (release_now) state_n = ST_COOL;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and acquired flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            held_q  <= cfg_hold && (state_n == ST_OWN);
        end
    end

    assign bus_busy = (state_q == ST_OWN);
    assign held     = held_q;

endmodule

// File: rtl/bus_requester_chk.sv
// Property checker for bus_requester, bound to every instance.
module bus_requester_chk #(
    parameter int NUM_LEVELS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_hold,
    input logic                  want,
    input logic                  cyc_done,
    input logic                  grant_in,
    input logic [NUM_LEVELS-1:0] req_out,
    input logic                  bus_busy,
    input logic                  held
);

    logic owned_once;

    // Remember whether any ownership has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        owned_once <= 1'b0;
        else if (bus_busy) owned_once <= 1'b1;
    end

    p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_out));

    p_first_top_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned_once && |req_out) |-> req_out[NUM_LEVELS-1]);

    p_own_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> ($past(grant_in) && |$past(req_out)));

    p_level_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(req_out) && |req_out) |-> (req_out == $past(req_out)));

    p_release_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> $past(cyc_done || !want));

    p_hold_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_busy) && $past(cfg_hold)) |-> bus_busy);

    p_held_owns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> bus_busy);

    p_cool_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |=> (req_out == '0));

endmodule

bind bus_requester bus_requester_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_hold (cfg_hold),
    .want     (want),
    .cyc_done (cyc_done),
    .grant_in (grant_in),
    .req_out  (req_out),
    .bus_busy (bus_busy),
    .held     (held)
);

// File: tb/test_bus_requester.sv
`timescale 1ns/1ps
// Directed bench for bus_requester: one task per scenario.
module test_bus_requester;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_level = 2'd0;
    logic       cfg_fair = 1'b0, cfg_hold = 1'b0, cfg_policy_en = 1'b1;
    logic [1:0] cfg_rel_mode = 2'd0;
    logic       cfg_rel_done = 1'b0;
    logic       want = 1'b0, cyc_done = 1'b0, timer_exp = 1'b0, fifo_stop = 1'b0;
    logic [3:0] bus_req_in = 4'd0;
    logic       grant_in = 1'b0;
    logic [3:0] req_out;
    logic       bus_busy, held;

    int vecs = 0;
    int errs = 0;
    logic [1:0] exp_lvl = 2'd3;

    always #2.5 clk = ~clk;

    bus_requester i_bus_requester (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Request, grant and own; expected level tracked in exp_lvl.
    task automatic acquire(input string tag);
        want = 1'b1;
        tick();
        chk({tag, " R3 request"}, 32'(req_out), 32'(4'b1 << exp_lvl));
        grant_in = 1'b1;
        tick();
        grant_in = 1'b0;
        exp_lvl = cfg_level;
        chk({tag, " R3 busy"}, 32'(bus_busy), 32'd1);
        chk({tag, " R3 req drop"}, 32'(req_out), 32'd0);
    endtask

    // Release by dropping want, then pass the cool-down cycle.
    task automatic drop_bus(input string tag);
        want = 1'b0;
        cyc_done = 1'b0;
        tick();
        chk({tag, " R7 want low release"}, 32'(bus_busy), 32'd0);
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 req", 32'(req_out), 32'd0);
        chk("R1 busy", 32'(bus_busy), 32'd0);
        chk("R1 held", 32'(held), 32'd0);
    endtask

    task automatic t_first_and_defer();
        cfg_level = 2'd1;
        acquire("R2 first");           // must request on level 3
        cfg_level = 2'd2;              // changed while owning
        drop_bus("R4");
        acquire("R4 old level");       // still level 1
        drop_bus("R4");
        acquire("R4 new level");       // now level 2
        drop_bus("R4");
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int o = 0; o < 2; o++) begin
                    logic exp_rel;
                    cfg_rel_mode = 2'(m);
                    bus_req_in = 4'd0;
                    acquire("R7 mode");
                    timer_exp = t[0];
                    bus_req_in = o[0] ? 4'b0001 : 4'b0000;
                    cyc_done = 1'b1;
                    case (m)
                        0: exp_rel = t[0] && o[0];
                        1: exp_rel = t[0];
                        2: exp_rel = o[0];
                        default: exp_rel = t[0] || o[0];
                    endcase
                    tick();
                    cyc_done = 1'b0;
                    timer_exp = 1'b0;
                    bus_req_in = 4'd0;
                    chk($sformatf("R7 mode%0d t%0d o%0d", m, t, o), 32'(bus_busy), 32'(!exp_rel));
                    if (bus_busy) drop_bus("R7");
                    else begin want = 1'b0; tick(); end
                end
            end
        end
    endtask

    task automatic t_boundary_and_cool();
        cfg_rel_mode = 2'd1;
        acquire("R6");
        timer_exp = 1'b1;
        tick();
        chk("R6 no boundary keeps", 32'(bus_busy), 32'd1);
        cyc_done = 1'b1;
        tick();
        cyc_done = 1'b0;
        timer_exp = 1'b0;
        chk("R6 boundary releases", 32'(bus_busy), 32'd0);
        chk("R11 req at release", 32'(req_out), 32'd0);
        tick();
        chk("R11 req one later", 32'(req_out), 32'd0);
        tick();
        chk("R11 request again", 32'(req_out), 32'(4'b1 << exp_lvl));
        want = 1'b0;
        tick();
    endtask

    task automatic t_fifo();
        cfg_rel_mode = 2'd0;
        acquire("R8");
        fifo_stop = 1'b1;
        cyc_done = 1'b1;
        tick();
        chk("R8 fifo releases", 32'(bus_busy), 32'd0);
        cyc_done = 1'b0; fifo_stop = 1'b0; want = 1'b0;
        tick();
        cfg_policy_en = 1'b0;
        cfg_rel_done = 1'b1;
        acquire("R8 simple");
        fifo_stop = 1'b1;
        cyc_done = 1'b1;
        tick();
        chk("R8 fifo ignored", 32'(bus_busy), 32'd1);
        cyc_done = 1'b0; fifo_stop = 1'b0;
        drop_bus("R8");
        cfg_policy_en = 1'b1;
    endtask

    task automatic t_simple();
        cfg_policy_en = 1'b0;
        cfg_rel_done = 1'b1;
        acquire("R9 done");
        bus_req_in = 4'b0100;
        cyc_done = 1'b1;
        tick();
        chk("R9 done ignores request", 32'(bus_busy), 32'd1);
        cyc_done = 1'b0; bus_req_in = 4'd0;
        drop_bus("R9");
        cfg_rel_done = 1'b0;
        acquire("R9 on request");
        want = 1'b0;
        tick();
        chk("R9 idle kept", 32'(bus_busy), 32'd1);
        bus_req_in = 4'b0010;
        tick();
        chk("R9 request releases", 32'(bus_busy), 32'd0);
        bus_req_in = 4'd0;
        tick();
        cfg_policy_en = 1'b1;
    endtask

    task automatic t_fair();
        cfg_fair = 1'b1;
        bus_req_in = 4'b1 << exp_lvl;
        want = 1'b1;
        tick();
        chk("R5 blocked", 32'(req_out), 32'd0);
        tick();
        chk("R5 still blocked", 32'(req_out), 32'd0);
        bus_req_in = 4'd0;
        tick();
        chk("R5 requests", 32'(req_out), 32'(4'b1 << exp_lvl));
        want = 1'b0;
        tick();
        cfg_fair = 1'b0;
    endtask

    task automatic t_hold();
        cfg_hold = 1'b1;
        want = 1'b0;
        tick();
        chk("R10 hold requests", 32'(req_out), 32'(4'b1 << exp_lvl));
        grant_in = 1'b1;
        tick();
        grant_in = 1'b0;
        exp_lvl = cfg_level;
        chk("R10 busy", 32'(bus_busy), 32'd1);
        chk("R10 held", 32'(held), 32'd1);
        timer_exp = 1'b1; fifo_stop = 1'b1; bus_req_in = 4'b1111; cyc_done = 1'b1;
        cfg_rel_mode = 2'd3;
        tick(); tick();
        chk("R10 kept", 32'(bus_busy), 32'd1);
        chk("R10 held kept", 32'(held), 32'd1);
        timer_exp = 1'b0; fifo_stop = 1'b0; bus_req_in = 4'd0; cyc_done = 1'b0;
        cfg_hold = 1'b0;
        tick();
        chk("R10 held clears", 32'(held), 32'd0);
        chk("R10 released", 32'(bus_busy), 32'd0);
        tick();
    endtask

    initial begin
        #200000;
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_and_defer();
        t_modes();
        t_boundary_and_cool();
        t_fifo();
        t_simple();
        t_fair();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule